// File: doc/BRIEF.md
# Triggered Logic Analyzer Capture Core

This block records a probe bus into a circular sample memory, one sample on every cycle of a free-running sample clock. It is armed by a single-cycle start pulse. It first stores the pre-trigger half of the window and only then begins to watch for the trigger. After the trigger it stores the remaining half and freezes, so the stored window is centred on the trigger sample.

The trigger is built from several comparator conditions. Each condition masks the probe bus and the programmed constant with a per-bit mask and then compares them with a selectable relational operator. The enabled conditions are merged by AND or by OR. An optional input register chain delays the probes before they reach both the memory and the comparators.

Once a capture has completed, a host reads the window through an offset port. Offset 0 returns the oldest retained sample and offsets rise toward the newest. A status output gives the capture state and the number of samples stored since arming. The memory address that holds the trigger sample is also reported.

Top module: `la_capture_core`

## Requirements
- R1: After reset, status_state is 0 (idle), sample_count is 0 and capture_valid is 0.
- R2: A start pulse seen in idle moves the core to state 1 (pre-fill) on the next clock, with sample_count cleared and capture_valid cleared. The core stays in pre-fill until DEPTH/2 samples are stored, and then moves to state 2 (waiting for trigger).
- R3: Trigger matches on samples stored during pre-fill are ignored. Only the first matching sample stored in state 2 becomes the trigger sample.
- R4: Each condition compares (probe AND mask) against (value AND mask), both unsigned. The 3-bit operator codes are 0 equal, 1 not equal, 2 less than, 3 greater than, 4 less or equal, 5 greater or equal; codes 6 and 7 never match.
- R5: With combine_or = 1, the trigger is the OR of the enabled conditions, so it never fires when none is enabled. With combine_or = 0, it is the AND of the enabled conditions, so it fires on the first candidate sample when none is enabled.
- R6: After the trigger sample, the core spends exactly DEPTH/2-1 cycles in state 3 (post-trigger), storing one sample per cycle. It then returns to idle with capture_valid = 1.
- R7: After a completed capture, rd_offset = k yields, one clock later on rd_data, the k-th oldest of the DEPTH retained samples; the trigger sample sits at offset DEPTH/2. trig_ptr equals the number of samples stored from arming up to the trigger sample, taken modulo DEPTH.
- R8: A start pulse while a capture is in progress is ignored: the state and the sample count continue unchanged.
- R9: An abort pulse returns the core to idle on the next clock, with capture_valid = 0.
- R10: With PIPE_STAGES = N, the first sample stored after arming is the probe value presented N cycles before the first write clock.
- R11: sample_count increases by one per stored sample and saturates at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst | input | 1 | Synchronous active-high reset |
| probe | input | PROBE_W | Observed signals |
| start | input | 1 | Arm pulse |
| abort | input | 1 | Return to idle, discard capture |
| cond_en | input | N_COND | Per-condition enable |
| cond_op | input | 3*N_COND | Operator code per condition |
| cond_value | input | PROBE_W*N_COND | Compare constant per condition |
| cond_mask | input | PROBE_W*N_COND | Care-bit mask per condition |
| combine_or | input | 1 | 1 = OR of conditions, 0 = AND |
| rd_offset | input | log2(DEPTH) | Readout offset from oldest sample |
| status_state | output | 2 | 0 idle, 1 pre-fill, 2 waiting, 3 post-trigger |
| sample_count | output | log2(DEPTH)+1 | Samples stored since arming (saturating) |
| capture_valid | output | 1 | Buffer holds a completed window |
| trig_ptr | output | log2(DEPTH) | Memory address of the trigger sample |
| rd_data | output | PROBE_W | Sample at rd_offset, one cycle latency |

## Verification
An error in the pre-fill counter appears on status_state and sample_count at the clock where the core should move from pre-fill to waiting. A wrong write pointer or oldest-sample base shows up as a break in the consecutive counter values the bench reads back, and as a trig_ptr that differs from the sample index the bench expects, as soon as the first capture completes. A trigger evaluated on the wrong sample, or during pre-fill, shifts the whole readout, so every offset of that capture mismatches. A faulty comparator or combine function is found in the one capture that uses it.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WAIT = 2'd2,
    ST_POST = 2'd3
  } cap_state_e;

  typedef enum logic [2:0] {
    OP_EQ = 3'd0,
    OP_NE = 3'd1,
    OP_LT = 3'd2,
    OP_GT = 3'd3,
    OP_LE = 3'd4,
    OP_GE = 3'd5
  } cmp_op_e;
endpackage

// File: rtl/la_probe_pipe.sv
module la_probe_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= din;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) stg[i] <= stg[i-1];
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/la_trigger_unit.sv
module la_trigger_unit
  import la_cap_pkg::*;
#(
  parameter int W      = 8,
  parameter int N_COND = 2
) (
  input  logic [W-1:0]        sample,
  input  logic [N_COND-1:0]   cond_en,
  input  logic [3*N_COND-1:0] cond_op,
  input  logic [W*N_COND-1:0] cond_value,
  input  logic [W*N_COND-1:0] cond_mask,
  input  logic                combine_or,
  output logic                trig_hit
);
  logic [N_COND-1:0] hit;

  for (genvar i = 0; i < N_COND; i++) begin : g_cond
    logic [W-1:0] lhs;
    logic [W-1:0] rhs;
    assign lhs = sample & cond_mask[i*W +: W];
    assign rhs = cond_value[i*W +: W] & cond_mask[i*W +: W];
    always_comb begin
      unique case (cond_op[i*3 +: 3])
        OP_EQ:   hit[i] = (lhs == rhs);
        OP_NE:   hit[i] = (lhs != rhs);
        OP_LT:   hit[i] = (lhs <  rhs);
        OP_GT:   hit[i] = (lhs >  rhs);
        OP_LE:   hit[i] = (lhs <= rhs);
        OP_GE:   hit[i] = (lhs >= rhs);
        default: hit[i] = 1'b0;
      endcase
    end
  end

  logic all_on;
  logic any_on;
  always_comb begin
    all_on = 1'b1;
    any_on = 1'b0;
    for (int i = 0; i < N_COND; i++) begin
      if (cond_en[i]) begin
        all_on = all_on & hit[i];
        any_on = any_on | hit[i];
      end
    end
    trig_hit = combine_or ? any_on : all_on;
  end

  // R5: in OR mode a trigger needs at least one enabled condition
  always_comb begin
    assert_or_needs_enable_R5: assert (!(combine_or && trig_hit) || (cond_en != '0));
  end
endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) rdata <= mem[raddr];
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int PRE  = DEPTH / 2,
  localparam int POST = DEPTH - PRE - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          trig_hit,
  output cap_state_e    state,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output logic [CW-1:0] sample_count,
  output logic          buf_valid,
  output logic [AW-1:0] trig_ptr,
  output logic [AW-1:0] oldest_ptr
);
  logic [AW-1:0] post_cnt;
  logic [CW-1:0] cnt_inc;

  assign wr_en   = (state != ST_IDLE);
  assign cnt_inc = (sample_count == CW'(DEPTH)) ? sample_count : sample_count + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      wr_ptr       <= '0;
      sample_count <= '0;
      buf_valid    <= 1'b0;
      trig_ptr     <= '0;
      oldest_ptr   <= '0;
      post_cnt     <= '0;
    end else if (abort) begin
      state     <= ST_IDLE;
      buf_valid <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state        <= ST_FILL;
            wr_ptr       <= '0;
            sample_count <= '0;
            buf_valid    <= 1'b0;
          end
        end
        ST_FILL: begin
          wr_ptr       <= wr_ptr + AW'(1);
          sample_count <= cnt_inc;
          if (sample_count == CW'(PRE - 1)) state <= ST_WAIT;
        end
        ST_WAIT: begin
          wr_ptr       <= wr_ptr + AW'(1);
          sample_count <= cnt_inc;
          if (trig_hit) begin
            trig_ptr <= wr_ptr;
            post_cnt <= '0;
            state    <= ST_POST;
          end
        end
        ST_POST: begin
          wr_ptr       <= wr_ptr + AW'(1);
          sample_count <= cnt_inc;
          post_cnt     <= post_cnt + AW'(1);
          if (post_cnt == AW'(POST - 1)) begin
            state      <= ST_IDLE;
            buf_valid  <= 1'b1;
            oldest_ptr <= wr_ptr + AW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_start_arms_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && !abort) |=> (state == ST_FILL && sample_count == '0 && !buf_valid));

  assert_no_early_trigger_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL) |=> (state != ST_POST));

  assert_valid_only_idle_R6: assert property (@(posedge clk) disable iff (rst)
    buf_valid |-> (state == ST_IDLE));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL && start && !abort) |=> (sample_count == $past(sample_count) + CW'(1)));

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (state == ST_IDLE && !buf_valid));

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (rst)
    sample_count <= CW'(DEPTH));
endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
  import la_cap_pkg::*;
#(
  parameter int PROBE_W     = 8,
  parameter int DEPTH       = 1024,
  parameter int N_COND      = 2,
  parameter int PIPE_STAGES = 0,
  localparam int AW         = $clog2(DEPTH),
  localparam int CW         = AW + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PROBE_W-1:0]        probe,
  input  logic                      start,
  input  logic                      abort,
  input  logic [N_COND-1:0]         cond_en,
  input  logic [3*N_COND-1:0]       cond_op,
  input  logic [PROBE_W*N_COND-1:0] cond_value,
  input  logic [PROBE_W*N_COND-1:0] cond_mask,
  input  logic                      combine_or,
  input  logic [AW-1:0]             rd_offset,
  output logic [1:0]                status_state,
  output logic [CW-1:0]             sample_count,
  output logic                      capture_valid,
  output logic [AW-1:0]             trig_ptr,
  output logic [PROBE_W-1:0]        rd_data
);
  logic [PROBE_W-1:0] smp;
  logic               trig_hit;
  cap_state_e         state;
  logic               wr_en;
  logic [AW-1:0]      wr_ptr;
  logic [AW-1:0]      oldest_ptr;

  if (PIPE_STAGES == 0) begin : g_nopipe
    assign smp = probe;
  end else begin : g_pipe
    la_probe_pipe #(.W(PROBE_W), .STAGES(PIPE_STAGES)) u_pipe (
      .clk  (clk),
      .din  (probe),
      .dout (smp)
    );
  end

  la_trigger_unit #(.W(PROBE_W), .N_COND(N_COND)) u_trig (
    .sample     (smp),
    .cond_en    (cond_en),
    .cond_op    (cond_op),
    .cond_value (cond_value),
    .cond_mask  (cond_mask),
    .combine_or (combine_or),
    .trig_hit   (trig_hit)
  );

  la_capture_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .abort        (abort),
    .trig_hit     (trig_hit),
    .state        (state),
    .wr_en        (wr_en),
    .wr_ptr       (wr_ptr),
    .sample_count (sample_count),
    .buf_valid    (capture_valid),
    .trig_ptr     (trig_ptr),
    .oldest_ptr   (oldest_ptr)
  );

  la_sample_ram #(.W(PROBE_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (smp),
    .raddr (oldest_ptr + rd_offset),
    .rdata (rd_data)
  );

  assign status_state = state;
endmodule

// File: tb/la_capture_core_bench.sv
module la_capture_core_bench;
  localparam int W = 8, D = 16, NC = 2, PIPE = 1, AW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, abort = 1'b0, orm = 1'b0;
  logic [W-1:0] probe = '0;
  logic [1:0] en = '0;
  logic [2:0] opc [2];
  logic [W-1:0] val [2];
  logic [W-1:0] msk [2];
  logic [AW-1:0] rd_off = '0;
  logic [1:0] st;
  logic [AW:0] cnt;
  logic vld;
  logic [AW-1:0] tptr;
  logic [W-1:0] rdat;

  la_capture_core #(.PROBE_W(W), .DEPTH(D), .N_COND(NC), .PIPE_STAGES(PIPE)) u_la_capture_core (
    .clk(clk), .rst(rst), .probe(probe), .start(start), .abort(abort),
    .cond_en(en), .cond_op({opc[1], opc[0]}), .cond_value({val[1], val[0]}),
    .cond_mask({msk[1], msk[0]}), .combine_or(orm), .rd_offset(rd_off),
    .status_state(st), .sample_count(cnt), .capture_valid(vld),
    .trig_ptr(tptr), .rd_data(rdat)
  );

  int checks = 0, errors = 0;

  always @(negedge clk) probe <= probe + 8'd1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard for readout
  logic [W-1:0] exp_q [$];
  logic issue = 1'b0, issue_d = 1'b0;
  always @(posedge clk) issue_d <= issue;
  always @(negedge clk) begin
    if (issue_d) begin
      logic [W-1:0] e;
      e = exp_q.pop_front();
      chk(rdat == e, "R7 R10 readout", rdat, e);
    end
  end

  function automatic bit ref_hit(logic [W-1:0] v);
    bit any = 0, all = 1;
    for (int i = 0; i < 2; i++) begin
      logic [W-1:0] a, b;
      bit h;
      a = v & msk[i];
      b = val[i] & msk[i];
      case (opc[i])
        3'd0: h = (a == b);
        3'd1: h = (a != b);
        3'd2: h = (a < b);
        3'd3: h = (a > b);
        3'd4: h = (a <= b);
        3'd5: h = (a >= b);
        default: h = 0;
      endcase
      if (en[i]) begin any |= h; all &= h; end
    end
    return orm ? any : all;
  endfunction

  task automatic set_cond(input int i, input bit e, input logic [2:0] o,
                          input logic [W-1:0] v, input logic [W-1:0] m);
    en[i] = e; opc[i] = o; val[i] = v; msk[i] = m;
  endtask

  task automatic pulse_start(output logic [W-1:0] s);
    @(negedge clk); #1; s = probe; start = 1'b1;
    @(negedge clk); #1; start = 1'b0;
  endtask

  task automatic run_capture(input bit busy_start);
    logic [W-1:0] s, t;
    int n, post_cycles;
    pulse_start(s);
    chk(st == 2'd1, "R2 state after start", st, 1);
    chk(cnt == 0 && vld == 1'b0, "R2 count/valid cleared", cnt, 0);
    if (busy_start) begin
      repeat (3) @(negedge clk);
      #1; start = 1'b1;
      @(negedge clk); #1; start = 1'b0;
      chk(st == 2'd1 && cnt == 4, "R8 start while busy ignored", cnt, 4);
      repeat (3) @(negedge clk);
    end else begin
      repeat (7) @(negedge clk);
    end
    #1;
    chk(st == 2'd1, "R2 still pre-fill", st, 1);
    @(negedge clk); #1;
    chk(st == 2'd2, "R2 R3 waiting after pre-fill", st, 2);
    chk(cnt == 8, "R11 count at pre-fill end", cnt, 8);
    t = s + 8'd8;
    n = 0;
    while (!ref_hit(t) && n < 256) begin t++; n++; end
    n = 0; post_cycles = 0;
    while (st != 2'd0 && n < 600) begin
      @(negedge clk); #1; n++;
      if (st == 2'd3) post_cycles++;
    end
    chk(post_cycles == D/2 - 1, "R6 post-trigger length", post_cycles, D/2 - 1);
    chk(vld == 1'b1, "R6 capture valid", vld, 1);
    chk(cnt == D, "R11 count saturates", cnt, D);
    chk(tptr == AW'(t - s), "R7 trigger pointer", tptr, AW'(t - s));
    for (int k = 0; k < D; k++) begin
      @(negedge clk); #1;
      rd_off = AW'(k);
      exp_q.push_back(t - 8'd8 + W'(k));
      issue = 1'b1;
    end
    @(negedge clk); #1; issue = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] s;
    for (int i = 0; i < 2; i++) set_cond(i, 0, 3'd0, '0, '1);
    repeat (3) @(negedge clk);
    #1;
    chk(st == 2'd0, "R1 reset state", st, 0);
    chk(cnt == 0 && vld == 1'b0, "R1 reset count/valid", cnt, 0);
    rst = 1'b0;

    // R4 equality, single condition, AND mode
    set_cond(0, 1, 3'd0, 8'h40, 8'hFF); orm = 0;
    run_capture(0);
    // R3 masked match recurring during pre-fill, OR mode
    set_cond(0, 1, 3'd0, 8'h01, 8'h03); orm = 1;
    run_capture(0);
    // R4 R5 greater/less combined by AND
    set_cond(0, 1, 3'd3, 8'h90, 8'hFF); set_cond(1, 1, 3'd2, 8'h95, 8'hFF); orm = 0;
    run_capture(0);
    // R4 R5 less-equal / greater-equal by OR, plus R8
    set_cond(0, 1, 3'd4, 8'h10, 8'hFF); set_cond(1, 1, 3'd5, 8'hF0, 8'hFF); orm = 1;
    run_capture(1);
    // R4 not-equal on top bit
    set_cond(0, 1, 3'd1, 8'h00, 8'h80); set_cond(1, 0, 3'd0, 8'h00, 8'hFF); orm = 0;
    run_capture(0);
    // R5 AND with nothing enabled fires at once
    set_cond(0, 0, 3'd0, 8'h00, 8'hFF);
    run_capture(0);
    // R5 OR with nothing enabled never fires; R9 abort
    orm = 1;
    pulse_start(s);
    chk(vld == 1'b0, "R2 start clears valid", vld, 0);
    repeat (40) @(negedge clk);
    #1;
    chk(st == 2'd2, "R5 OR with none enabled keeps waiting", st, 2);
    abort = 1'b1;
    @(negedge clk); #1; abort = 1'b0;
    chk(st == 2'd0 && vld == 1'b0, "R9 abort to idle", st, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule